// File: doc/BRIEF.md
# Byte-Parity SRAM Error Monitor

This block sits beside a 32-bit SRAM port and guards it with byte parity. Whenever the bus presents write data, the block drives one parity bit per byte lane toward the array, and the array stores those bits with the word. A read returns its data and the stored parity one cycle after the request. In that cycle the block recomputes the parity of every lane and compares it with the stored bits.

A mismatch on any lane sets a sticky error flag. If capture is enabled and the flag was clear, the block also records three things: which lanes failed, the word-aligned offset of the access, and the identity code of the bus master that made the request. The flag drives either a level-sensitive maskable interrupt or a non-maskable interrupt. The NMI select is a one-way switch that only reset turns off.

Software reaches the control, enable, status, clear and record registers through a simple synchronous register bus. The register bus reads combinationally. A single input pin stands for the stored option that allows parity checking at all. Read data goes from the array to the requester directly; the block only observes it.

Top module: `bpar_mon`

## Requirements
- R1: `ram_wpar[i]` is the even parity (XOR) of byte lane i of `mb_wdata`, for every lane, in the same cycle.
- R2: A parity check happens only if `opt_par_en` is 1 and at least one of IE (enable register bit 0) or NE (enable register bit 1) is 1. Otherwise a corrupted read leaves the flag at 0.
- R3: A read requested in cycle T is checked against `ram_rdata`/`ram_rpar` in cycle T+1. A failing lane makes the status flag (status register, address 2, bit 0) read 1 from cycle T+2.
- R4: The record is captured only when ALE (control register, address 0, bit 0) is 1. With ALE at 0, an error sets the flag but leaves the record unchanged.
- R5: The record is captured only while the flag is 0. Later errors do not change it until the flag has been cleared.
- R6: The record register (address 4) reads as follows: bits 31:28 hold the failing-lane mask, with bit 28 for lane 0 and bit 31 for lane 3. Bits 27:24 hold the master code, zero-extended (CPU 010, USB 001, debugger 011, DMA port 0 110, DMA port 1 111). Bits 23:16 are zero. Bits 15:0 hold the byte offset of the word, `{mb_word, 2'b00}`.
- R7: The mask reports every failing lane of the physical word, including lanes that the requester's (possibly unaligned) access did not need.
- R8: Writing 1 to enable bit 1 sets NE. Writing 0 to it does not clear it; only reset does. `nmi` equals flag AND NE.
- R9: `irq` equals flag AND IE AND NOT NE, so `irq` and `nmi` are never both high.
- R10: Writing 1 to clear-register bit 0 (address 3) clears the flag, and writing 0 has no effect. Reading address 3 returns the flag in bit 0. An error checked in the same cycle as a clear leaves the flag set.
- R11: After reset, every register reads 0 and `irq` and `nmi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opt_par_en | input | 1 | Stored option that permits parity checking |
| mb_rd_en | input | 1 | Memory-bus read request this cycle |
| mb_word | input | 14 | Word offset of the accessed physical word |
| mb_mid | input | 3 | Master code of the requester |
| mb_wdata | input | 32 | Write data going to the array |
| ram_wpar | output | 4 | Per-lane parity to store with the write data |
| ram_rdata | input | 32 | Read data from the array (cycle after request) |
| ram_rpar | input | 4 | Stored parity read back with the data |
| rb_wr | input | 1 | Register-bus write strobe |
| rb_addr | input | 3 | Register index |
| rb_wdata | input | 32 | Register write data |
| rb_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Maskable parity interrupt, level |
| nmi | output | 1 | Non-maskable parity interrupt, level |

## Verification
On every cycle, assertions check the following:
- `irq` and `nmi` are exclusive.
- NE never drops outside reset.
- The flag stays set unless a clear is written.
- The flag rises only after a returned read while the option pin was high.
- The record is frozen while the flag is set or capture is disabled.

Only the bench scenarios can show that the captured fields hold the right lane mask, master code and offset for particular corruptions. The scenarios also show that a clear arriving alongside a new error loses to it, and that the check stays silent when its gating conditions are absent.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

   // register bus geometry and register indices
   localparam int RB_AW = 3;
   localparam logic [RB_AW-1:0] RA_CTRL = 3'd0;
   localparam logic [RB_AW-1:0] RA_ENA  = 3'd1;
   localparam logic [RB_AW-1:0] RA_STAT = 3'd2;
   localparam logic [RB_AW-1:0] RA_CLR  = 3'd3;
   localparam logic [RB_AW-1:0] RA_REC  = 3'd4;

   // fixed record layout: lane mask, master code, gap, byte offset
   function automatic logic [31:0] pack_rec(input logic [3:0] lanes,
                                            input logic [3:0] master,
                                            input logic [15:0] offset);
      return {lanes, master, 8'h00, offset};
   endfunction

endpackage

// File: rtl/bpar_parity_bank.sv
module bpar_parity_bank #(
   parameter int LANES = 4,
   parameter bit ODD   = 1'b0
) (
   input  logic [LANES*8-1:0] data,
   output logic [LANES-1:0]   par
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (ODD) begin : g_odd
         assign par[i] = ~^data[i*8 +: 8];
      end else begin : g_even
         assign par[i] = ^data[i*8 +: 8];
      end
   end

endmodule

// File: rtl/bpar_err_log.sv
module bpar_err_log #(
   parameter int LANES   = 4,
   parameter int MID_W   = 3,
   parameter int WORD_AW = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LANES-1:0]   fail,
   input  logic [MID_W-1:0]   fail_mid,
   input  logic [WORD_AW-1:0] fail_word,
   input  logic               ale,
   input  logic               clr,
   output logic               flag,
   output logic [LANES-1:0]   rec_mask,
   output logic [MID_W-1:0]   rec_mid,
   output logic [WORD_AW-1:0] rec_word
);

   logic hit;
   assign hit = |fail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag     <= 1'b0;
         rec_mask <= '0;
         rec_mid  <= '0;
         rec_word <= '0;
      end else begin
         // a new error outranks a clear in the same cycle
         if (hit)      flag <= 1'b1;
         else if (clr) flag <= 1'b0;
         if (hit && ale && !flag) begin
            rec_mask <= fail;
            rec_mid  <= fail_mid;
            rec_word <= fail_word;
         end
      end
   end

   // R10: flag only drops through a clear
   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   // R5: first record frozen while flag set
   assert_rec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flag |=> ($stable(rec_mask) && $stable(rec_mid) && $stable(rec_word)));

   // R4: no capture without latch enable
   assert_rec_needs_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |=> ($stable(rec_mask) && $stable(rec_mid) && $stable(rec_word)));

endmodule

// File: rtl/bpar_mon.sv
module bpar_mon
   import bpar_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int OFF_W      = 16,
   parameter int MID_W      = 3,
   parameter bit ODD_PARITY = 1'b0,
   localparam int LANES     = DATA_W / 8,
   localparam int LANE_AW   = $clog2(LANES),
   localparam int WORD_AW   = OFF_W - LANE_AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               opt_par_en,
   input  logic               mb_rd_en,
   input  logic [WORD_AW-1:0] mb_word,
   input  logic [MID_W-1:0]   mb_mid,
   input  logic [DATA_W-1:0]  mb_wdata,
   output logic [LANES-1:0]   ram_wpar,
   input  logic [DATA_W-1:0]  ram_rdata,
   input  logic [LANES-1:0]   ram_rpar,
   input  logic               rb_wr,
   input  logic [RB_AW-1:0]   rb_addr,
   input  logic [31:0]        rb_wdata,
   output logic [31:0]        rb_rdata,
   output logic               irq,
   output logic               nmi
);

   // elaboration-time parameter checks
   if (!(DATA_W == 16 || DATA_W == 32)) begin : g_bad_dw
      $error("bpar_mon: DATA_W must be 16 or 32");
   end
   if (OFF_W > 16 || OFF_W <= LANE_AW) begin : g_bad_off
      $error("bpar_mon: OFF_W out of range");
   end
   if (MID_W < 1 || MID_W > 4) begin : g_bad_mid
      $error("bpar_mon: MID_W must be 1..4");
   end

   logic               ale_q, ie_q, ne_q;
   logic               rd_pend_q;
   logic [WORD_AW-1:0] rd_word_q;
   logic [MID_W-1:0]   rd_mid_q;
   logic [LANES-1:0]   rd_par, fail;
   logic               check_on, clr, flag;
   logic [LANES-1:0]   rec_mask;
   logic [MID_W-1:0]   rec_mid;
   logic [WORD_AW-1:0] rec_word;
   logic               unused_rb;

   assign unused_rb = ^rb_wdata[31:2];

   // write-side parity generation
   bpar_parity_bank #(.LANES(LANES), .ODD(ODD_PARITY)) u_wgen (
      .data (mb_wdata),
      .par  (ram_wpar)
   );

   // read-side recomputation
   bpar_parity_bank #(.LANES(LANES), .ODD(ODD_PARITY)) u_rchk (
      .data (ram_rdata),
      .par  (rd_par)
   );

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ale_q <= 1'b0;
         ie_q  <= 1'b0;
         ne_q  <= 1'b0;
      end else if (rb_wr) begin
         if (rb_addr == RA_CTRL) ale_q <= rb_wdata[0];
         if (rb_addr == RA_ENA) begin
            ie_q <= rb_wdata[0];
            if (rb_wdata[1]) ne_q <= 1'b1;
         end
      end
   end

   // request tag, consumed when the array returns data
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pend_q <= 1'b0;
         rd_word_q <= '0;
         rd_mid_q  <= '0;
      end else begin
         rd_pend_q <= mb_rd_en;
         if (mb_rd_en) begin
            rd_word_q <= mb_word;
            rd_mid_q  <= mb_mid;
         end
      end
   end

   assign check_on = opt_par_en && (ie_q || ne_q);
   assign fail     = (rd_par ^ ram_rpar) & {LANES{rd_pend_q && check_on}};
   assign clr      = rb_wr && (rb_addr == RA_CLR) && rb_wdata[0];

   bpar_err_log #(.LANES(LANES), .MID_W(MID_W), .WORD_AW(WORD_AW)) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .fail      (fail),
      .fail_mid  (rd_mid_q),
      .fail_word (rd_word_q),
      .ale       (ale_q),
      .clr       (clr),
      .flag      (flag),
      .rec_mask  (rec_mask),
      .rec_mid   (rec_mid),
      .rec_word  (rec_word)
   );

   assign nmi = flag && ne_q;
   assign irq = flag && ie_q && !ne_q;

   always_comb begin
      rb_rdata = '0;
      case (rb_addr)
         RA_CTRL: rb_rdata[0]   = ale_q;
         RA_ENA:  rb_rdata[1:0] = {ne_q, ie_q};
         RA_STAT: rb_rdata[0]   = flag;
         RA_CLR:  rb_rdata[0]   = flag;
         RA_REC:  rb_rdata = pack_rec(4'(rec_mask), 4'(rec_mid),
                                      16'({rec_word, {LANE_AW{1'b0}}}));
         default: rb_rdata = '0;
      endcase
   end

   // R9: maskable and non-maskable outputs never coincide
   assert_irq_nmi_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && nmi));

   // R8: NE is one-way outside reset
   assert_ne_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ne_q |=> ne_q);

   // R3: flag rises only after a returned read
   assert_flag_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(rd_pend_q));

   // R2: flag rises only with checking permitted
   assert_flag_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(opt_par_en) && ($past(ie_q) || $past(ne_q))));

endmodule

// File: tb/bpar_mon_tb_top.sv
module bpar_mon_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        opt_par_en = 1'b0;
   logic        mb_rd_en = 1'b0;
   logic [13:0] mb_word = '0;
   logic [2:0]  mb_mid = '0;
   logic [31:0] mb_wdata = '0;
   logic [3:0]  ram_wpar;
   logic [31:0] ram_rdata;
   logic [3:0]  ram_rpar;
   logic        rb_wr = 1'b0;
   logic [2:0]  rb_addr = '0;
   logic [31:0] rb_wdata = '0;
   logic [31:0] rb_rdata;
   logic        irq, nmi;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   bpar_mon dut_i (
      .clk(clk), .rst_n(rst_n), .opt_par_en(opt_par_en),
      .mb_rd_en(mb_rd_en), .mb_word(mb_word), .mb_mid(mb_mid),
      .mb_wdata(mb_wdata), .ram_wpar(ram_wpar),
      .ram_rdata(ram_rdata), .ram_rpar(ram_rpar),
      .rb_wr(rb_wr), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
      .rb_rdata(rb_rdata), .irq(irq), .nmi(nmi)
   );

   // array model: 64 words of data plus parity, one-cycle read latency
   logic [35:0] mem [0:63];
   logic [35:0] rdq = '0;
   always @(posedge clk) if (mb_rd_en) rdq <= mem[mb_word[5:0]];
   assign ram_rdata = rdq[31:0];
   assign ram_rpar  = rdq[35:32];

   // {word 14, master 3, data 32, parity flip 4}
   localparam logic [52:0] VEC [6] = '{
      {14'h0002, 3'b010, 32'h1234_5678, 4'b0001},
      {14'h0003, 3'b001, 32'hFFFF_FFFF, 4'b1000},
      {14'h0004, 3'b011, 32'h0000_0000, 4'b0110},
      {14'h0010, 3'b110, 32'hA5A5_0F0F, 4'b0000},
      {14'h0011, 3'b111, 32'h8000_0001, 4'b1111},
      {14'h3FFF, 3'b010, 32'hDEAD_BEEF, 4'b1001}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] even_par(input logic [31:0] d);
      return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0]};
   endfunction

   task automatic rb_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      rb_wr = 1'b1; rb_addr = a; rb_wdata = d;
      @(negedge clk);
      rb_wr = 1'b0; rb_wdata = '0;
   endtask

   task automatic rb_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rb_addr = a;
      #1 d = rb_rdata;
   endtask

   task automatic wr_word(input logic [13:0] w, input logic [31:0] d);
      @(negedge clk);
      mb_wdata = d;
      #1;
      check("R1 write parity", {28'h0, ram_wpar}, {28'h0, even_par(d)});
      mem[w[5:0]] = {ram_wpar, d};
   endtask

   task automatic corrupt(input logic [13:0] w, input logic [3:0] flip);
      mem[w[5:0]] = mem[w[5:0]] ^ {flip, 32'h0};
   endtask

   // returns at the negedge where the check result is visible (T+2)
   task automatic rd_word(input logic [13:0] w, input logic [2:0] mid);
      @(negedge clk);
      mb_rd_en = 1'b1; mb_word = w; mb_mid = mid;
      @(negedge clk);
      mb_rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         report();
         $finish;
      end
   end

   initial begin
      logic [31:0] d, rec_a;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      opt_par_en = 1'b1;

      // R11 reset state
      for (int a = 0; a < 5; a++) begin
         rb_read(3'(a), d);
         check("R11 reset register", d, 32'h0);
      end
      check("R11 reset irq/nmi", {30'h0, irq, nmi}, 32'h0);

      // R2: option pin low blocks checking
      rb_write(3'd1, 32'h1);
      opt_par_en = 1'b0;
      wr_word(14'h1, 32'h0F0F_00FF);
      corrupt(14'h1, 4'b0001);
      rd_word(14'h1, 3'b010);
      rb_read(3'd2, d);
      check("R2 option low", d, 32'h0);
      // R2: no enables blocks checking
      opt_par_en = 1'b1;
      rb_write(3'd1, 32'h0);
      rd_word(14'h1, 3'b010);
      rb_read(3'd2, d);
      check("R2 no enables", d, 32'h0);

      // R3/R4: error with capture disabled
      rb_write(3'd1, 32'h1);
      rd_word(14'h1, 3'b010);
      check("R3 flag via irq at T+2", {31'h0, irq}, 32'h1);
      check("R9 nmi low with IE only", {31'h0, nmi}, 32'h0);
      rb_read(3'd2, d);
      check("R3 flag set", d, 32'h1);
      rb_read(3'd4, d);
      check("R4 no capture without ALE", d, 32'h0);

      // R10 clear behaviour
      rb_write(3'd3, 32'h0);
      rb_read(3'd2, d);
      check("R10 write 0 ignored", d, 32'h1);
      rb_read(3'd3, d);
      check("R10 clear reg reads flag", d, 32'h1);
      rb_write(3'd3, 32'h1);
      rb_read(3'd3, d);
      check("R10 flag cleared", d, 32'h0);
      check("R9 irq drops", {31'h0, irq}, 32'h0);

      // table walk with capture enabled: R6, R7
      rb_write(3'd0, 32'h1);
      for (int v = 0; v < 6; v++) begin
         logic [13:0] w;
         logic [2:0]  m;
         logic [31:0] dat;
         logic [3:0]  fl;
         {w, m, dat, fl} = VEC[v];
         wr_word(w, dat);
         corrupt(w, fl);
         rd_word(w, m);
         rb_read(3'd2, d);
         check("R3 table flag", d, {31'h0, fl != 4'b0});
         if (fl != 4'b0) begin
            rb_read(3'd4, d);
            check("R6 R7 table record", d, {fl, 1'b0, m, 8'h00, w, 2'b00});
         end
         rb_write(3'd3, 32'h1);
      end

      // R5: first record held
      rd_word(14'h0002, 3'b010);
      rb_read(3'd4, rec_a);
      check("R5 first record", rec_a, {4'b0001, 4'b0010, 8'h00, 16'h0008});
      rd_word(14'h0003, 3'b001);
      rb_read(3'd4, d);
      check("R5 record not overwritten", d, rec_a);

      // R10: error and clear in the same cycle, error wins
      @(negedge clk);
      mb_rd_en = 1'b1; mb_word = 14'h0004; mb_mid = 3'b011;
      @(negedge clk);
      mb_rd_en = 1'b0;
      rb_wr = 1'b1; rb_addr = 3'd3; rb_wdata = 32'h1;
      @(negedge clk);
      rb_wr = 1'b0; rb_wdata = '0;
      rb_read(3'd2, d);
      check("R10 set beats clear", d, 32'h1);
      rb_read(3'd4, d);
      check("R5 no capture while set", d, rec_a);

      // R8/R9 NMI select
      rb_write(3'd1, 32'h3);
      check("R8 nmi high", {31'h0, nmi}, 32'h1);
      check("R9 irq masked by NE", {31'h0, irq}, 32'h0);
      rb_write(3'd1, 32'h0);
      rb_read(3'd1, d);
      check("R8 NE not cleared by write", d, 32'h2);
      rb_write(3'd3, 32'h1);
      check("R8 nmi follows flag", {31'h0, nmi}, 32'h0);
      rd_word(14'h0002, 3'b110);
      check("R2 R8 NE alone enables check", {30'h0, irq, nmi}, 32'h1);

      // R8/R11: only reset clears NE
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rb_read(3'd1, d);
      check("R8 R11 NE cleared by reset", d, 32'h0);
      check("R11 outputs after reset", {30'h0, irq, nmi}, 32'h0);

      done = 1'b1;
      report();
      $finish;
   end

endmodule